// File: doc/BRIEF.md
# Serial-wire debug link bring-up sequencer

This block drives the fixed start-up of a two-wire serial debug link. It sits above two lower engines that it does not contain. The first is a raw bit shifter, which clocks an arbitrary pattern onto the data line, least significant bit first. The second is a transaction engine, which runs one complete request, acknowledge and data exchange with the target and returns the 3-bit acknowledge, the read word and a read-parity flag.

On a `start` pulse the sequencer gives the engines eight commands in a fixed order:

1. A long run of ones on the line.
2. The 16-bit protocol switch pattern.
3. A second long run of ones.
4. A short gap of low idle clocks.
5. A debug-port identification read.
6. A debug-port select write that picks the memory access port.
7. A posted access-port identification read.
8. A debug-port read-buffer read that fetches that posted value.

Each command is a one-cycle `go` pulse with its fields held, and the sequencer waits for the engine's `done` before it continues. The identification word is compared with a parameter. The run ends with `pass` set, or with a step number and a failure kind that name where the run stopped and why. A `WAIT` acknowledge is retried a bounded number of times.

Step numbers: 1 first line reset, 2 switch pattern, 3 second line reset, 4 idle gap, 5 identification read, 6 select write, 7 access-port read, 8 read-buffer read.

Failure kinds: 0 none, 1 acknowledge neither OK nor WAIT, 2 WAIT retries exhausted, 3 read parity error, 4 identification mismatch.

Top module: `swd_bringup`

## Requirements
- R1: Commands 1 and 3 are raw commands with length `RST_LEN` (50 or more, default 56) and data of all ones in bits `RST_LEN-1:0`.
- R2: Command 2 is a raw command of length 16 with data 16'hE79E; the shifter sends bit 0 first.
- R3: Command 4 is a raw command of `IDLE_CYC` zero bits (2 or more).
- R4: Step 5 is a debug-port read (`xfer_ap`=0, `xfer_rnw`=1, `xfer_addr`=0). Its word appears on `idcode`. A word that differs from `EXP_ID` ends the run with step 5 and kind 4.
- R5: Step 6 is a debug-port write (`xfer_ap`=0, `xfer_rnw`=0, `xfer_addr`=2) carrying `SEL_VAL`.
- R6: Step 7 is an access-port read at `xfer_addr`=3, whose returned word and parity flag are ignored. Step 8 is a debug-port read at `xfer_addr`=3; its word appears on `apid`, and the run ends with `pass`=1 and kind 0.
- R7: An acknowledge of 3'b010 (WAIT) reissues the same command, up to `MAX_WAIT` times per step. One more WAIT ends the run with that step and kind 2.
- R8: An acknowledge that is neither 3'b001 (OK) nor WAIT ends the run at once with that step and kind 1. No further command is issued.
- R9: A parity flag on the step 5 or step 8 read ends the run with that step and kind 3.
- R10: Every command is a single-cycle `go` pulse. `start` has no effect while `busy` is high. `idcode` and `apid` are cleared at start and hold their values after the run.
- R11: After reset, `busy`, `done`, `pass`, both `go` outputs and both ID words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a bring-up run |
| raw_go | output | 1 | Raw shift command pulse |
| raw_len | output | $clog2(RAW_W+1) | Number of bits to shift |
| raw_data | output | RAW_W | Bits to shift, bit 0 first |
| raw_done | input | 1 | Raw shift finished |
| xfer_go | output | 1 | Transaction command pulse |
| xfer_ap | output | 1 | 1 = access port, 0 = debug port |
| xfer_rnw | output | 1 | 1 = read, 0 = write |
| xfer_addr | output | 2 | Register address bits 3:2 |
| xfer_wdata | output | 32 | Write word |
| xfer_done | input | 1 | Transaction finished |
| xfer_ack | input | 3 | Acknowledge, bit 0 first on the wire |
| xfer_rdata | input | 32 | Read word |
| xfer_perr | input | 1 | Read parity error |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until the next start |
| pass | output | 1 | Run completed without error |
| err_step | output | 4 | Step where the run stopped (0 on pass) |
| err_kind | output | 3 | Failure kind (0 on pass) |
| idcode | output | 32 | Identification word |
| apid | output | 32 | Access-port identification word |

## Verification
The assertions check, on every cycle, the properties of single commands:
- each `go` lasts exactly one cycle;
- nothing is issued while idle;
- a transaction never carries an illegal port and address pairing;
- `pass` rises only just after an engine completion;
- the ID words stay stable between runs.

Only the bench scenarios can show the order of the eight commands and the WAIT retry limit at each transaction step. The same holds for the step and kind reported for every injected fault, for the fact that the posted access-port read's parity is ignored, and for a `start` arriving mid-run leaving the sequence intact.

// File: rtl/swd_bringup.sv
module swd_bringup #(
  parameter int RAW_W    = 64,
  parameter int RST_LEN  = 56,
  parameter int IDLE_CYC = 2,
  parameter logic [31:0] EXP_ID  = 32'h1BA01477,
  parameter logic [31:0] SEL_VAL = 32'h000000F0,
  parameter int MAX_WAIT = 4,
  localparam int LW = $clog2(RAW_W + 1),
  localparam int WW = $clog2(MAX_WAIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             raw_go,
  output logic [LW-1:0]    raw_len,
  output logic [RAW_W-1:0] raw_data,
  input  logic             raw_done,
  output logic             xfer_go,
  output logic             xfer_ap,
  output logic             xfer_rnw,
  output logic [1:0]       xfer_addr,
  output logic [31:0]      xfer_wdata,
  input  logic             xfer_done,
  input  logic [2:0]       xfer_ack,
  input  logic [31:0]      xfer_rdata,
  input  logic             xfer_perr,
  output logic             busy,
  output logic             done,
  output logic             pass,
  output logic [3:0]       err_step,
  output logic [2:0]       err_kind,
  output logic [31:0]      idcode,
  output logic [31:0]      apid
);
  typedef enum logic [3:0] {
    S_IDLE = 4'd0, S_RST1 = 4'd1, S_SWITCH = 4'd2, S_RST2 = 4'd3, S_GAP = 4'd4,
    S_RDID = 4'd5, S_WRSEL = 4'd6, S_RDAP = 4'd7, S_RDBUF = 4'd8
  } state_t;

  localparam logic [RAW_W-1:0] ONES = {RAW_W{1'b1}} >> (RAW_W - RST_LEN);
  localparam logic [RAW_W-1:0] SWPAT = {{(RAW_W-16){1'b0}}, 16'hE79E};
  localparam logic [2:0] ACK_OK = 3'b001, ACK_WAIT = 3'b010;

  state_t         st;
  logic           issued;
  logic [WW-1:0]  wait_cnt;
  logic           is_raw, is_xfer;

  assign busy       = st != S_IDLE;
  assign is_raw     = st inside {S_RST1, S_SWITCH, S_RST2, S_GAP};
  assign is_xfer    = st inside {S_RDID, S_WRSEL, S_RDAP, S_RDBUF};
  assign raw_go     = is_raw && !issued;
  assign xfer_go    = is_xfer && !issued;
  assign xfer_ap    = st == S_RDAP;
  assign xfer_rnw   = st != S_WRSEL;
  assign xfer_wdata = SEL_VAL;

  always_comb begin
    raw_len   = '0;
    raw_data  = '0;
    xfer_addr = 2'd0;
    case (st)
      S_RST1, S_RST2: begin raw_len = LW'(RST_LEN); raw_data = ONES; end
      S_SWITCH:       begin raw_len = LW'(16);      raw_data = SWPAT; end
      S_GAP:          raw_len = LW'(IDLE_CYC);
      S_WRSEL:        xfer_addr = 2'd2;
      S_RDAP, S_RDBUF: xfer_addr = 2'd3;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; issued <= 1'b0; wait_cnt <= '0;
      done <= 1'b0; pass <= 1'b0; err_step <= '0; err_kind <= '0;
      idcode <= '0; apid <= '0;
    end else if (!busy) begin
      if (start) begin
        st <= S_RST1; issued <= 1'b0; wait_cnt <= '0;
        done <= 1'b0; pass <= 1'b0; err_step <= '0; err_kind <= '0;
        idcode <= '0; apid <= '0;
      end
    end else if (!issued) begin
      issued <= 1'b1;
    end else if (is_raw && raw_done) begin
      st <= state_t'(st + 4'd1);
      issued <= 1'b0;
    end else if (is_xfer && xfer_done) begin
      issued <= 1'b0;
      if (xfer_ack == ACK_WAIT && wait_cnt < WW'(MAX_WAIT)) begin
        wait_cnt <= wait_cnt + 1'b1;
      end else if (xfer_ack != ACK_OK) begin
        st <= S_IDLE; done <= 1'b1; err_step <= st;
        err_kind <= (xfer_ack == ACK_WAIT) ? 3'd2 : 3'd1;
      end else if (xfer_perr && (st == S_RDID || st == S_RDBUF)) begin
        st <= S_IDLE; done <= 1'b1; err_step <= st; err_kind <= 3'd3;
      end else begin
        wait_cnt <= '0;
        if (st == S_RDID) begin
          idcode <= xfer_rdata;
          if (xfer_rdata != EXP_ID) begin
            st <= S_IDLE; done <= 1'b1; err_step <= st; err_kind <= 3'd4;
          end else st <= S_WRSEL;
        end else if (st == S_RDBUF) begin
          apid <= xfer_rdata;
          st <= S_IDLE; done <= 1'b1; pass <= 1'b1;
        end else begin
          st <= state_t'(st + 4'd1);
        end
      end
    end
  end
endmodule

// File: rtl/swd_bringup_chk.sv
module swd_bringup_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        raw_go,
  input logic        xfer_go,
  input logic        xfer_done,
  input logic        xfer_ap,
  input logic        xfer_rnw,
  input logic [1:0]  xfer_addr,
  input logic        pass,
  input logic        done,
  input logic [2:0]  err_kind,
  input logic [31:0] idcode,
  input logic [31:0] apid
);
  a_r10_raw_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    raw_go |=> !raw_go);
  a_r10_xfer_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go |=> !xfer_go);
  a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !raw_go && !xfer_go);
  a_r6_ap_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_go && xfer_ap) |-> (xfer_rnw && xfer_addr == 2'd3));
  a_r6_pass_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> ($past(xfer_done) && done && err_kind == 3'd0));
  a_r10_ids_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(idcode) && $stable(apid)));
endmodule

bind swd_bringup swd_bringup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .raw_go(raw_go),
  .xfer_go(xfer_go), .xfer_done(xfer_done), .xfer_ap(xfer_ap),
  .xfer_rnw(xfer_rnw), .xfer_addr(xfer_addr), .pass(pass), .done(done),
  .err_kind(err_kind), .idcode(idcode), .apid(apid)
);

// File: tb/swd_bringup_tb.sv
module swd_bringup_tb;
  localparam int RAW_W = 64, RST_LEN = 56, IDLE_CYC = 2, MAX_WAIT = 4;
  localparam logic [31:0] EXP_ID = 32'h1BA01477, SEL_VAL = 32'h000000F0;
  localparam logic [31:0] AP_VAL = 32'h14770011;
  localparam int LW = $clog2(RAW_W + 1);

  logic clk = 0, rst_n = 0, start = 0;
  logic raw_go, raw_done = 0, xfer_go, xfer_ap, xfer_rnw, xfer_done = 0, xfer_perr = 0;
  logic [LW-1:0] raw_len;
  logic [RAW_W-1:0] raw_data;
  logic [1:0] xfer_addr;
  logic [31:0] xfer_wdata, xfer_rdata = 0, idcode, apid;
  logic [2:0] xfer_ack = 0, err_kind;
  logic [3:0] err_step;
  logic busy, done, pass;

  int checks = 0, errors = 0;
  int pos = 0, gos = 0;
  int fail_step = 0, wait_step = 0, wait_n = 0, perr_step = 0;
  logic [2:0] fail_ack = 3'b100;
  bit bad_id = 0;

  always #2 clk = ~clk;

  swd_bringup #(.RAW_W(RAW_W), .RST_LEN(RST_LEN), .IDLE_CYC(IDLE_CYC), .EXP_ID(EXP_ID),
                .SEL_VAL(SEL_VAL), .MAX_WAIT(MAX_WAIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .raw_go(raw_go), .raw_len(raw_len),
    .raw_data(raw_data), .raw_done(raw_done), .xfer_go(xfer_go), .xfer_ap(xfer_ap),
    .xfer_rnw(xfer_rnw), .xfer_addr(xfer_addr), .xfer_wdata(xfer_wdata),
    .xfer_done(xfer_done), .xfer_ack(xfer_ack), .xfer_rdata(xfer_rdata),
    .xfer_perr(xfer_perr), .busy(busy), .done(done), .pass(pass), .err_step(err_step),
    .err_kind(err_kind), .idcode(idcode), .apid(apid));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Engine model: checks each command against the expected order and answers it.
  initial begin
    forever begin
      if (raw_go || xfer_go) begin
        int s;
        s = pos + 1;
        gos++;
        if (raw_go) begin
          logic [RAW_W-1:0] ed;
          logic [LW-1:0] el;
          chk(s <= 4, "R10 raw command order", 64'(s), 64'd4);
          case (s)
            1, 3: begin el = LW'(RST_LEN); ed = '0; for (int i = 0; i < RST_LEN; i++) ed[i] = 1'b1; end
            2: begin el = LW'(16); ed = RAW_W'(16'hE79E); end
            default: begin el = LW'(IDLE_CYC); ed = '0; end
          endcase
          if (s == 2) chk(raw_len == el && raw_data == ed, "R2 switch pattern", 64'(raw_data), 64'(ed));
          else if (s == 4) chk(raw_len == el && raw_data == ed, "R3 idle gap", 64'(raw_len), 64'(el));
          else chk(raw_len == el && raw_data == ed, "R1 line reset", 64'(raw_data), 64'(ed));
          repeat (2) @(posedge clk);
          #1 raw_done = 1;
          @(posedge clk);
          #1 raw_done = 0;
          pos++;
        end else begin
          logic [35:0] got, exp;
          got = {xfer_ap, xfer_rnw, xfer_addr, xfer_wdata};
          case (s)
            5: exp = {1'b0, 1'b1, 2'd0, SEL_VAL};
            6: exp = {1'b0, 1'b0, 2'd2, SEL_VAL};
            7: exp = {1'b1, 1'b1, 2'd3, SEL_VAL};
            default: exp = {1'b0, 1'b1, 2'd3, SEL_VAL};
          endcase
          if (s == 5) chk(got == exp, "R4 id read fields", 64'(got), 64'(exp));
          else if (s == 6) chk(got == exp, "R5 select write fields", 64'(got), 64'(exp));
          else chk(got == exp && s <= 8, "R6 ap read fields", 64'(got), 64'(exp));
          repeat (2) @(posedge clk);
          #1;
          xfer_perr = 0;
          xfer_rdata = 32'h0BAD0BAD;
          if (s == wait_step && wait_n > 0) begin
            xfer_ack = 3'b010; wait_n--;
          end else if (s == fail_step) begin
            xfer_ack = fail_ack;
          end else begin
            xfer_ack = 3'b001;
            if (s == 5) xfer_rdata = bad_id ? 32'hDEADBEEF : EXP_ID;
            if (s == 8) xfer_rdata = AP_VAL;
            xfer_perr = (s == perr_step);
            pos++;
          end
          xfer_done = 1;
          @(posedge clk);
          #1 xfer_done = 0;
        end
      end else begin
        @(posedge clk);
        #1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic run(input int fs, input logic [2:0] fa, input int ws, input int wn,
                     input int ps, input bit bid, input bit poke);
    fail_step = fs; fail_ack = fa; wait_step = ws; wait_n = wn; perr_step = ps; bad_id = bid;
    pos = 0; gos = 0;
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
    if (poke) begin
      repeat (20) @(posedge clk);
      #1 start = 1;
      @(posedge clk); #1 start = 0;
    end
    while (busy) begin @(posedge clk); #1; end
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic expect_fail(input string req, input int step, input int kind);
    chk(done && !pass && err_step == 4'(step) && err_kind == 3'(kind), req,
        {32'(err_step), 29'd0, err_kind}, {32'(step), 29'd0, 3'(kind)});
    chk(gos >= step && !raw_go && !xfer_go, "R8 no command after abort", 64'(gos), 64'(step));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !done && !pass && !raw_go && !xfer_go && idcode == 0 && apid == 0,
        "R11 reset state", {busy, done, pass, raw_go, xfer_go}, 64'd0);
    rst_n = 1;

    run(0, 3'b100, 0, 0, 0, 0, 0);
    chk(done && pass && err_kind == 0 && err_step == 0, "R6 clean pass", {pass, err_kind}, {1'b1, 3'd0});
    chk(idcode == EXP_ID, "R4 id word", 64'(idcode), 64'(EXP_ID));
    chk(apid == AP_VAL, "R6 ap id via read buffer", 64'(apid), 64'(AP_VAL));
    chk(gos == 8, "R10 eight commands", 64'(gos), 64'd8);
    repeat (5) @(posedge clk);
    #1 chk(idcode == EXP_ID && apid == AP_VAL, "R10 ids held", 64'(apid), 64'(AP_VAL));

    run(0, 3'b100, 0, 0, 0, 0, 1);
    chk(pass && gos == 8, "R10 start ignored while busy", 64'(gos), 64'd8);

    for (int s = 5; s <= 8; s++) begin
      run(s, 3'b100, 0, 0, 0, 0, 0);
      expect_fail("R8 fault ack", s, 1);
      run(s, 3'b111, 0, 0, 0, 0, 0);
      expect_fail("R8 invalid ack", s, 1);
      run(0, 3'b100, s, MAX_WAIT, 0, 0, 0);
      chk(pass && gos == 8 + MAX_WAIT, "R7 waits within limit", 64'(gos), 64'(8 + MAX_WAIT));
      run(0, 3'b100, s, MAX_WAIT + 1, 0, 0, 0);
      expect_fail("R7 waits exhausted", s, 2);
      chk(gos == s + MAX_WAIT, "R7 retry count", 64'(gos), 64'(s + MAX_WAIT));
    end

    run(6, 3'b100, 0, 0, 0, 0, 0);
    chk(idcode == EXP_ID && apid == 0, "R10 apid cleared at start", 64'(apid), 64'd0);

    run(0, 3'b100, 0, 0, 5, 0, 0);
    expect_fail("R9 parity on id read", 5, 3);
    run(0, 3'b100, 0, 0, 8, 0, 0);
    expect_fail("R9 parity on buffer read", 8, 3);
    run(0, 3'b100, 0, 0, 7, 0, 0);
    chk(pass && apid == AP_VAL, "R6 posted read parity ignored", 64'(pass), 64'd1);

    run(0, 3'b100, 0, 0, 0, 1, 0);
    expect_fail("R4 id mismatch", 5, 4);
    chk(idcode == 32'hDEADBEEF && gos == 5, "R4 mismatched word shown", 64'(idcode), 64'hDEADBEEF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule